// File: doc/BRIEF.md
# Half-Duplex Transmit Access and Collision Backoff Controller

This block decides when one half-duplex Ethernet port may put a frame on a shared medium. Time is counted in bit times, with one clock per bit. A client raises a request together with the frame length in bits. The controller then waits until carrier sense has stayed low for a full interframe spacing. After that it raises a per-bit transmit enable for exactly that many clocks.

If a collision is reported while the frame is on the wire, the data stops and a fixed-length jam follows. The controller then counts the attempt and waits a random number of slot times before it defers again. That number is drawn from a free-running linear feedback shift register and masked to an exponent that grows with the attempt count and is capped. A clean finish raises a one-clock success pulse. Too many collisions on one frame raise a one-clock abort pulse, and the frame is dropped.

The sequencer has five states:
- IDLE: waits for a request. IDLE→DEFER on a request.
- DEFER: counts consecutive quiet bits, and carrier restarts the count. DEFER→SEND after the full spacing.
- SEND: drives the frame bits. SEND→IDLE on the last bit without collision. SEND→JAM on a collision.
- JAM: drives the jam. JAM→BACKOFF after the jam while attempts remain. JAM→IDLE with abort once the limit is exceeded.
- BACKOFF: waits out the chosen number of slots. BACKOFF→DEFER when the slots have run out.

Top module: `cbo_tx_access`

## Requirements
- R1: While reset is held, and after it until a request arrives, `tx_bit_en`, `jam_active`, `tx_done` and `tx_abort` are all low.
- R2: With carrier low, the first frame bit appears at the output GAP_BITS clocks after the clock edge that accepts the request.
- R3: Carrier seen during deferral restarts the spacing, so the first bit appears exactly GAP_BITS clocks after carrier falls, and never in the clock right after carrier was high.
- R4: Without collision, `tx_bit_en` is high for exactly the requested number of clocks, and `tx_done` is high for one clock, in the clock right after the last bit.
- R5: A collision sampled during a frame bit ends the frame after that bit, and `jam_active` is then high for exactly JAM_BITS clocks.
- R6: After the jam for attempt N (N counted from 1), the retry's first bit appears 1 + r*SLOT_BITS + GAP_BITS clocks after the jam ends, with 0 ≤ r < 2^min(N,EXP_CAP).
- R7: When the attempt count after a jam exceeds MAX_ATTEMPTS (the collision numbered MAX_ATTEMPTS+1), `tx_abort` pulses for one clock in the clock right after the jam, and no further bits or jam follow.
- R8: The attempt count restarts at zero for every accepted request, so the first collision of a new frame always backs off by r < 2.
- R9: A request held high while the controller is deferring or sending is ignored: the frame is neither lengthened nor restarted, and no new frame begins after `tx_done`.
- R10: A collision outside a frame bit (during deferral) has no effect: no jam, and the start time is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_req | input | 1 | Request to send a frame, sampled only in IDLE |
| tx_len_bits | input | LEN_W | Frame length in bits, latched with the request (0 treated as 1) |
| carrier_sense | input | 1 | Medium busy |
| collision | input | 1 | Collision detected on the medium |
| tx_bit_en | output | 1 | One frame bit is sent this clock |
| jam_active | output | 1 | One jam bit is sent this clock |
| tx_done | output | 1 | One-clock pulse: frame sent without collision |
| tx_abort | output | 1 | One-clock pulse: frame dropped after too many collisions |

## Verification
Each result is due after a fixed number of clocks:
- First bit: GAP_BITS clocks after acceptance, or after carrier falls.
- Success pulse: in the clock right after the last bit. The abort pulse and the start of the jam come in the clock right after the jam or collision that causes them.
- Retry: exactly 1 + r*SLOT_BITS + GAP_BITS clocks after the jam.

The bench drives inputs and samples outputs on falling edges. It measures every interval by counting those edges from the stimulus. Because the random slot count cannot be predicted without copying the generator, each retry interval is checked for its exact form and for the bound set by the attempt number.

// File: rtl/cbo_pkg.sv
package cbo_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEFER,
        ST_SEND,
        ST_JAM,
        ST_BACKOFF
    } cbo_state_t;
endpackage

// File: rtl/cbo_prng.sv
module cbo_prng #(
    parameter int            W     = 16,
    parameter int            OUT_W = 10,
    parameter logic [W-1:0]  SEED  = 16'hACE1,
    parameter logic [W-1:0]  TAPS  = 16'hB400
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= SEED;
        else        q <= {1'b0, q[W-1:1]} ^ (q[0] ? TAPS : '0);
    end

    assign rnd = q[OUT_W-1:0];
endmodule

// File: rtl/cbo_bit_counter.sv
module cbo_bit_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) q <= '0;
        else               q <= q + 1'b1;
    end
endmodule

// File: rtl/cbo_slot_timer.sv
module cbo_slot_timer #(
    parameter int SLOT_BITS = 512,
    parameter int SLOTS_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [SLOTS_W-1:0] load_slots,
    input  logic               run,
    output logic               expired
);
    localparam int SB_W = $clog2(SLOT_BITS + 1);

    logic [SLOTS_W-1:0] slots_left;
    logic [SB_W-1:0]    bit_in_slot;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_left  <= '0;
            bit_in_slot <= '0;
        end else if (load) begin
            slots_left  <= load_slots;
            bit_in_slot <= '0;
        end else if (run && slots_left != '0) begin
            if (bit_in_slot == SB_W'(SLOT_BITS - 1)) begin
                bit_in_slot <= '0;
                slots_left  <= slots_left - 1'b1;
            end else begin
                bit_in_slot <= bit_in_slot + 1'b1;
            end
        end
    end

    assign expired = (slots_left == '0);
endmodule

// File: rtl/cbo_tx_access.sv
module cbo_tx_access
    import cbo_pkg::*;
#(
    parameter int                GAP_BITS     = 96,
    parameter int                SLOT_BITS    = 512,
    parameter int                JAM_BITS     = 32,
    parameter int                MAX_ATTEMPTS = 16,
    parameter int                EXP_CAP      = 10,
    parameter int                LEN_W        = 14,
    parameter int                PRNG_W       = 16,
    parameter logic [PRNG_W-1:0] PRNG_SEED    = 16'hACE1,
    parameter logic [PRNG_W-1:0] PRNG_TAPS    = 16'hB400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_req,
    input  logic [LEN_W-1:0] tx_len_bits,
    input  logic             carrier_sense,
    input  logic             collision,
    output logic             tx_bit_en,
    output logic             jam_active,
    output logic             tx_done,
    output logic             tx_abort
);
    localparam int GAP_W = $clog2(GAP_BITS + 1);
    localparam int JAM_W = $clog2(JAM_BITS + 1);
    localparam int MX1_W = (LEN_W > GAP_W) ? LEN_W : GAP_W;
    localparam int CNT_W = ((MX1_W > JAM_W) ? MX1_W : JAM_W) + 1;
    localparam int ATT_W = $clog2(MAX_ATTEMPTS + 2);

    cbo_state_t         state_q, state_d;
    logic [CNT_W-1:0]   cnt;
    logic               cnt_clr;
    logic [LEN_W-1:0]   len_q;
    logic [ATT_W-1:0]   att_q;
    logic [ATT_W-1:0]   att_next;
    logic [EXP_CAP-1:0] rnd;
    logic [EXP_CAP-1:0] exp_mask;
    logic               bo_expired;
    logic               gap_met, last_bit, jam_last, over_limit;

    cbo_prng #(
        .W(PRNG_W), .OUT_W(EXP_CAP), .SEED(PRNG_SEED), .TAPS(PRNG_TAPS)
    ) u_prng (
        .clk(clk), .rst_n(rst_n), .rnd(rnd)
    );

    cbo_bit_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .q(cnt)
    );

    cbo_slot_timer #(.SLOT_BITS(SLOT_BITS), .SLOTS_W(EXP_CAP)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (state_q == ST_JAM && jam_last),
        .load_slots (rnd & exp_mask),
        .run        (state_q == ST_BACKOFF),
        .expired    (bo_expired)
    );

    assign att_next   = att_q + 1'b1;
    assign over_limit = (att_q >= ATT_W'(MAX_ATTEMPTS));
    assign gap_met    = !carrier_sense && (cnt == CNT_W'(GAP_BITS - 1));
    assign last_bit   = (cnt == CNT_W'(len_q) - CNT_W'(1));
    assign jam_last   = (cnt == CNT_W'(JAM_BITS - 1));

    always_comb begin
        for (int i = 0; i < EXP_CAP; i++) exp_mask[i] = (i < int'(att_next));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (tx_req)   state_d = ST_DEFER;
            ST_DEFER:   if (gap_met)  state_d = ST_SEND;
            ST_SEND:    if (collision)     state_d = ST_JAM;
                        else if (last_bit) state_d = ST_IDLE;
            ST_JAM:     if (jam_last) state_d = over_limit ? ST_IDLE : ST_BACKOFF;
            ST_BACKOFF: if (bo_expired) state_d = ST_DEFER;
            default:    state_d = ST_IDLE;
        endcase
    end

    assign cnt_clr = (state_d != state_q) || (state_q == ST_DEFER && carrier_sense);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            len_q   <= '0;
            att_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && tx_req) begin
                len_q <= (tx_len_bits == '0) ? LEN_W'(1) : tx_len_bits;
                att_q <= '0;
            end else if (state_q == ST_JAM && jam_last && !over_limit) begin
                att_q <= att_next;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_done  <= 1'b0;
            tx_abort <= 1'b0;
        end else begin
            tx_done  <= (state_q == ST_SEND) && !collision && last_bit;
            tx_abort <= (state_q == ST_JAM) && jam_last && over_limit;
        end
    end

    assign tx_bit_en  = (state_q == ST_SEND);
    assign jam_active = (state_q == ST_JAM);
endmodule

// File: rtl/cbo_tx_access_checker.sv
module cbo_tx_access_checker (
    input logic clk,
    input logic rst_n,
    input logic carrier_sense,
    input logic collision,
    input logic tx_bit_en,
    input logic jam_active,
    input logic tx_done,
    input logic tx_abort
);
    p_done_one_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    p_done_after_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> ($past(tx_bit_en) && !tx_bit_en));

    p_jam_follows_col_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_bit_en && collision) |=> (jam_active && !tx_bit_en));

    p_jam_needs_col_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jam_active) |-> $past(collision && tx_bit_en));

    p_quiet_before_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_bit_en) |-> $past(!carrier_sense));

    p_abort_one_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |=> !tx_abort);

    p_abort_after_jam_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |-> ($past(jam_active) && !jam_active && !tx_bit_en));

    p_quiet_in_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !(tx_bit_en || jam_active || tx_done || tx_abort));
endmodule

bind cbo_tx_access cbo_tx_access_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .carrier_sense (carrier_sense),
    .collision     (collision),
    .tx_bit_en     (tx_bit_en),
    .jam_active    (jam_active),
    .tx_done       (tx_done),
    .tx_abort      (tx_abort)
);

// File: tb/cbo_tx_access_bench.sv
`timescale 1ns/1ps
module cbo_tx_access_bench;
    localparam int GAP  = 96;
    localparam int SLOT = 4;
    localparam int JAM  = 32;
    localparam int MAXA = 16;
    localparam int CAP  = 10;
    localparam int LW   = 12;
    localparam int NV   = 6;
    localparam int TV_LEN  [NV] = '{64, 100, 1, 80, 72, 200};
    localparam int TV_HOLD [NV] = '{0, 40, 0, 0, 10, 150};
    localparam int TV_COL  [NV] = '{-1, -1, -1, 0, 71, 33};

    logic clk = 1'b0, rst_n = 1'b0, tx_req = 1'b0;
    logic carrier_sense = 1'b0, collision = 1'b0;
    logic [LW-1:0] tx_len_bits = '0;
    logic tx_bit_en, jam_active, tx_done, tx_abort;
    int n_chk = 0, n_bad = 0;
    bit saw_jam;

    always #2 clk = ~clk;

    cbo_tx_access #(
        .GAP_BITS(GAP), .SLOT_BITS(SLOT), .JAM_BITS(JAM),
        .MAX_ATTEMPTS(MAXA), .EXP_CAP(CAP), .LEN_W(LW)
    ) u_cbo_tx_access (
        .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_len_bits(tx_len_bits),
        .carrier_sense(carrier_sense), .collision(collision),
        .tx_bit_en(tx_bit_en), .jam_active(jam_active),
        .tx_done(tx_done), .tx_abort(tx_abort)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge where the first bit is seen.
    task automatic launch(input int len, input int hold, input bit keep_req,
                          input bit poke_col, output int dly);
        tx_req = 1'b1; tx_len_bits = LW'(len); carrier_sense = (hold > 0);
        dly = 0;
        do begin
            @(negedge clk); dly++;
            if (jam_active) saw_jam = 1'b1;
            if (!keep_req) tx_req = 1'b0;
            carrier_sense = (dly < hold);
            collision = poke_col && !tx_bit_en && (dly % 7 == 3);
        end while (!tx_bit_en && dly < 100000);
        collision = 1'b0;
    endtask

    task automatic measure_on(input int colbit, output int on);
        on = 0;
        do begin
            collision = (on == colbit);
            @(negedge clk);
            collision = 1'b0;
            on++;
        end while (tx_bit_en && on < 100000);
        tx_req = 1'b0;
    endtask

    task automatic measure_jam(output int jl);
        jl = 0;
        while (jam_active && jl < 100000) begin
            @(negedge clk); jl++;
        end
    endtask

    task automatic measure_retry(output int w);
        w = 0;
        while (!tx_bit_en && w < 100000) begin
            @(negedge clk); w++;
        end
    endtask

    function automatic bit retry_ok(input int w, input int n);
        int e = (n < CAP) ? n : CAP;
        if (w < 1 + GAP) return 1'b0;
        if ((w - 1 - GAP) % SLOT != 0) return 1'b0;
        return ((w - 1 - GAP) / SLOT) < (1 << e);
    endfunction

    task automatic finish_clean(input int len, input string rq);
        int on;
        measure_on(-1, on);
        check(on == len, rq, on, len);
        check(tx_done == 1'b1, "R4 done pulse after last bit", tx_done, 1);
        @(negedge clk);
        check(tx_done == 1'b0, "R4 done lasts one clock", tx_done, 0);
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int dly, on, jl, w;
        bit quiet;
        // R1: reset state
        repeat (4) @(negedge clk);
        check(!(tx_bit_en || jam_active || tx_done || tx_abort), "R1 outputs low in reset",
              {tx_bit_en, jam_active, tx_done, tx_abort}, 0);
        rst_n = 1'b1;
        quiet = 1'b1;
        repeat (150) begin
            @(negedge clk);
            if (tx_bit_en || jam_active || tx_done || tx_abort) quiet = 1'b0;
        end
        check(quiet, "R1 idle without request", quiet, 1);

        // Table walk: R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            saw_jam = 1'b0;
            launch(TV_LEN[v], TV_HOLD[v], 1'b0, 1'b0, dly);
            check(dly == ((TV_HOLD[v] > 0) ? TV_HOLD[v] : 1) + GAP,
                  (TV_HOLD[v] > 0) ? "R3 start after carrier" : "R2 start after gap",
                  dly, ((TV_HOLD[v] > 0) ? TV_HOLD[v] : 1) + GAP);
            if (TV_COL[v] < 0) begin
                finish_clean(TV_LEN[v], "R4 bit count");
            end else begin
                measure_on(TV_COL[v], on);
                check(on == TV_COL[v] + 1, "R5 bits up to collision", on, TV_COL[v] + 1);
                measure_jam(jl);
                check(jl == JAM, "R5 jam length", jl, JAM);
                measure_retry(w);
                check(retry_ok(w, 1), "R6 first retry delay", w, 1 + GAP);
                finish_clean(TV_LEN[v], "R4 bit count on retry");
            end
        end

        // R9: request held high through deferral and frame
        launch(50, 0, 1'b1, 1'b0, dly);
        check(dly == 1 + GAP, "R9 held request no restart", dly, 1 + GAP);
        finish_clean(50, "R9 frame not lengthened");
        quiet = 1'b1;
        repeat (GAP + 20) begin
            @(negedge clk);
            if (tx_bit_en) quiet = 1'b0;
        end
        check(quiet, "R9 no second frame", quiet, 1);

        // R10: collision during deferral ignored
        saw_jam = 1'b0;
        launch(30, 0, 1'b0, 1'b1, dly);
        check(dly == 1 + GAP && !saw_jam, "R10 collision in defer ignored", dly, 1 + GAP);
        finish_clean(30, "R10 frame completes");

        // R7 / R6: collide on every attempt until abort
        launch(64, 0, 1'b0, 1'b0, dly);
        for (int n = 1; n <= MAXA + 1; n++) begin
            measure_on(0, on);
            measure_jam(jl);
            if (n <= MAXA) begin
                check(tx_abort == 1'b0, "R7 no abort within limit", tx_abort, 0);
                measure_retry(w);
                check(retry_ok(w, n), "R6 retry bound grows with attempt", w, n);
            end else begin
                check(tx_abort == 1'b1, "R7 abort after limit exceeded", tx_abort, 1);
                @(negedge clk);
                check(tx_abort == 1'b0, "R7 abort lasts one clock", tx_abort, 0);
                quiet = 1'b1;
                repeat (GAP + 4 * SLOT + 50) begin
                    @(negedge clk);
                    if (tx_bit_en || jam_active) quiet = 1'b0;
                end
                check(quiet, "R7 nothing after abort", quiet, 1);
            end
        end

        // R8: attempt counter restarts on a new request
        launch(20, 0, 1'b0, 1'b0, dly);
        measure_on(2, on);
        measure_jam(jl);
        measure_retry(w);
        check(retry_ok(w, 1), "R8 fresh attempt count", w, 1 + GAP);
        finish_clean(20, "R8 frame completes");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule